// File: doc/BRIEF.md
# DSI Transmit Lane Timing Sequencer

This block sequences the entry into and exit from high-speed mode for one D-PHY clock lane and one data lane on the transmit side. A one-cycle request pulse starts a burst. The clock lane moves through prepare, zero and a clock-lead interval. The data lane then runs its own prepare and zero intervals and holds HS active until an end-of-burst pulse is seen. The data lane then trails and exits, and the clock lane runs its post and trail intervals before it returns to stop. Every interval is a programmed count of lane byte-clock cycles. One byte clock equals eight high-speed bit times.

The clock lane goes into HS before the data lane starts and leaves HS only after the data lane has begun its trail. Its post count is therefore programmed as the wanted post time plus the data trail time. Software can take any of the four lane enables away from the state machines through a select/value pair. A force-stop input and per-lane power-down inputs hold the lanes in stop.

States of the clock lane: CL_STOP, CL_PREP, CL_ZERO, CL_PRE, CL_HS, CL_POST, CL_TRAIL. Its transitions are: STOP→PREP on an accepted request, PREP→ZERO, ZERO→PRE, PRE→HS and POST→TRAIL when the interval ends, HS→POST when the data lane is seen in trail or the data lane is held, TRAIL→STOP when the interval ends, and any state→STOP on clock power-down. States of the data lane: DL_STOP, DL_PREP, DL_ZERO, DL_HS, DL_TRAIL, DL_EXIT. Its transitions are: STOP→PREP when the clock lane is in CL_HS, PREP→ZERO, ZERO→HS, TRAIL→EXIT and EXIT→STOP when the interval ends, HS→TRAIL on an end request, and any state→STOP while held.

Top module: `dsi_lane_seq`

## Requirements
- R1: After reset, and whenever idle, both lanes are in stop: clk_lp_en and dat_lp_en are 1, and clk_hs_en and dat_hs_en are 0.
- R2: A request pulse is accepted only when both lanes are in stop and no hold is active. clk_hs_en is 1 from the cycle after the pulse. The clock lane spends its prepare count and then its zero count before clock hs_active rises.
- R3: A timing field of N ≥ 1 makes its state last N cycles, and a field of 0 makes it last exactly one cycle. The clock-lane word is {prepare[31:24], zero[23:16], post[15:8], trail[7:0]}. The data-lane word is {prepare[31:24], zero[23:16], trail[15:8], exit[7:0]}.
- R4: The clock-lead interval (clk_pre) follows the clock zero. The data lane enters prepare one cycle after the clock lane enters CL_HS, with dat_hs_en going to 1. It then spends its prepare and zero counts before data hs_active rises.
- R5: An end pulse that arrives after the request but before data HS active is held, and the data lane leaves HS after one HS-active cycle. An end pulse during HS active ends it at the next cycle. An end pulse while idle has no effect.
- R6: After HS active, the data lane keeps dat_hs_en high for its trail count. It then drives dat_lp_en for its exit count before reporting stop.
- R7: The clock post interval starts one cycle after the data lane enters trail, and clock hs_active covers CL_PRE, CL_HS and CL_POST. The clock trail count follows, and then the clock lane reaches stop.
- R8: Each status nibble is {top, tx_stop, tx_ulps, tx_hs_active}, and tx_ulps is always 0. The clock-lane top bit is bias_ready, and the data-lane top bit is always 0.
- R9: The override bits are ordered [3] clock hs_en, [2] clock lp_en, [1] data hs_en and [0] data lp_en. A select bit of 1 drives the enable from ovr_val. Overrides do not change the lane states or status.
- R10: force_stop sends the data lane to stop at the next cycle and keeps it there. The clock lane then runs post and trail, and requests are ignored while force_stop is high.
- R11: pwr_down[1] powers down the whole block: both lanes go to stop and all four enables read 0, overrides included. pwr_down[0] zeroes and stops only the data lane.
- R12: A request pulse during a burst is ignored, and no second burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | lane byte clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hs_req | input | 1 | one-cycle request to start a burst |
| burst_end | input | 1 | one-cycle end-of-burst request |
| force_stop | input | 1 | hold the data lane in stop |
| pwr_down | input | 2 | [1] clock lane / whole block, [0] data lane |
| bias_ready | input | 1 | bias-ready flag reported in clock status |
| clk_tim | input | 4*CNT_W | clock-lane counts {prepare, zero, post, trail} |
| dat_tim | input | 4*CNT_W | data-lane counts {prepare, zero, trail, exit} |
| clk_pre | input | CNT_W | clock-lead count before data launch |
| ovr_sel | input | 4 | per-enable override select |
| ovr_val | input | 4 | per-enable override value |
| clk_hs_en | output | 1 | clock-lane HS driver enable |
| clk_lp_en | output | 1 | clock-lane LP driver enable |
| dat_hs_en | output | 1 | data-lane HS driver enable |
| dat_lp_en | output | 1 | data-lane LP driver enable |
| clk_status | output | 4 | clock-lane status nibble |
| dat_status | output | 4 | data-lane status nibble |

## Verification
The properties assume that requests and end pulses last a single cycle. They also assume that the timing words stay constant while a burst is running, so each interval is loaded once from a stable value. The stimulus changes the timing words only while both lanes sit in stop. It draws the counts from small ranges that include zero, and it pulses the strobes for exactly one cycle. The end pulse is placed at random points both before and during HS active, so that the held and the direct end paths are both taken.

// File: rtl/dsi_lane_seq_pkg.sv
package dsi_lane_seq_pkg;

    typedef enum logic [2:0] {
        CL_STOP,
        CL_PREP,
        CL_ZERO,
        CL_PRE,
        CL_HS,
        CL_POST,
        CL_TRAIL
    } clk_state_e;

    typedef enum logic [2:0] {
        DL_STOP,
        DL_PREP,
        DL_ZERO,
        DL_HS,
        DL_TRAIL,
        DL_EXIT
    } dat_state_e;

endpackage

// File: rtl/lane_interval_cnt.sv
// Down-counter for one timed interval; a load of 0 or 1 gives a single cycle.
module lane_interval_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= init;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign last = (cnt <= W'(1));
endmodule

// File: rtl/dsi_clk_lane_fsm.sv
module dsi_clk_lane_fsm
    import dsi_lane_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         dat_trail,
    input  logic         abort,
    input  logic         off,
    input  logic [W-1:0] t_prep,
    input  logic [W-1:0] t_zero,
    input  logic [W-1:0] t_pre,
    input  logic [W-1:0] t_post,
    input  logic [W-1:0] t_trail,
    output clk_state_e   state,
    output logic         hs_en,
    output logic         lp_en,
    output logic         hs_active
);
    clk_state_e   nxt;
    logic [W-1:0] init;
    logic         last;

    always_comb begin
        nxt = state;
        unique case (state)
            CL_STOP:  if (start)              nxt = CL_PREP;
            CL_PREP:  if (last)               nxt = CL_ZERO;
            CL_ZERO:  if (last)               nxt = CL_PRE;
            CL_PRE:   if (last)               nxt = CL_HS;
            CL_HS:    if (dat_trail || abort) nxt = CL_POST;
            CL_POST:  if (last)               nxt = CL_TRAIL;
            CL_TRAIL: if (last)               nxt = CL_STOP;
            default:                          nxt = CL_STOP;
        endcase
        if (off) nxt = CL_STOP;
    end

    always_comb begin
        unique case (nxt)
            CL_PREP:  init = t_prep;
            CL_ZERO:  init = t_zero;
            CL_PRE:   init = t_pre;
            CL_POST:  init = t_post;
            CL_TRAIL: init = t_trail;
            default:  init = '0;
        endcase
    end

    lane_interval_cnt #(.W(W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (nxt != state),
        .init (init),
        .last (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CL_STOP;
        else        state <= nxt;
    end

    always_comb begin
        hs_en     = (state != CL_STOP);
        lp_en     = (state == CL_STOP);
        hs_active = (state == CL_PRE) || (state == CL_HS) || (state == CL_POST);
    end
endmodule

// File: rtl/dsi_dat_lane_fsm.sv
module dsi_dat_lane_fsm
    import dsi_lane_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic         end_req,
    input  logic         hold,
    input  logic [W-1:0] t_prep,
    input  logic [W-1:0] t_zero,
    input  logic [W-1:0] t_trail,
    input  logic [W-1:0] t_exit,
    output dat_state_e   state,
    output logic         hs_en,
    output logic         lp_en,
    output logic         hs_active
);
    dat_state_e   nxt;
    logic [W-1:0] init;
    logic         last;

    always_comb begin
        nxt = state;
        unique case (state)
            DL_STOP:  if (launch)  nxt = DL_PREP;
            DL_PREP:  if (last)    nxt = DL_ZERO;
            DL_ZERO:  if (last)    nxt = DL_HS;
            DL_HS:    if (end_req) nxt = DL_TRAIL;
            DL_TRAIL: if (last)    nxt = DL_EXIT;
            DL_EXIT:  if (last)    nxt = DL_STOP;
            default:               nxt = DL_STOP;
        endcase
        if (hold) nxt = DL_STOP;
    end

    always_comb begin
        unique case (nxt)
            DL_PREP:  init = t_prep;
            DL_ZERO:  init = t_zero;
            DL_TRAIL: init = t_trail;
            DL_EXIT:  init = t_exit;
            default:  init = '0;
        endcase
    end

    lane_interval_cnt #(.W(W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (nxt != state),
        .init (init),
        .last (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DL_STOP;
        else        state <= nxt;
    end

    always_comb begin
        hs_en     = (state == DL_PREP) || (state == DL_ZERO) ||
                    (state == DL_HS)   || (state == DL_TRAIL);
        lp_en     = (state == DL_STOP) || (state == DL_EXIT);
        hs_active = (state == DL_HS);
    end
endmodule

// File: rtl/dsi_lane_seq.sv
module dsi_lane_seq
    import dsi_lane_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_req,
    input  logic               burst_end,
    input  logic               force_stop,
    input  logic [1:0]         pwr_down,
    input  logic               bias_ready,
    input  logic [4*CNT_W-1:0] clk_tim,
    input  logic [4*CNT_W-1:0] dat_tim,
    input  logic [CNT_W-1:0]   clk_pre,
    input  logic [3:0]         ovr_sel,
    input  logic [3:0]         ovr_val,
    output logic               clk_hs_en,
    output logic               clk_lp_en,
    output logic               dat_hs_en,
    output logic               dat_lp_en,
    output logic [3:0]         clk_status,
    output logic [3:0]         dat_status
);
    localparam int F3 = 4*CNT_W;
    localparam int F2 = 3*CNT_W;
    localparam int F1 = 2*CNT_W;
    localparam int F0 = CNT_W;
    localparam int N_EN = 4;

    clk_state_e cl_st;
    dat_state_e dl_st;
    logic c_hs, c_lp, c_act, d_hs, d_lp, d_act;
    logic dat_hold, start, clk_busy, dat_early, pend, end_req;

    assign dat_hold  = force_stop | pwr_down[0] | pwr_down[1];
    assign start     = hs_req && (cl_st == CL_STOP) && (dl_st == DL_STOP) && !dat_hold;
    assign clk_busy  = (cl_st == CL_PREP) || (cl_st == CL_ZERO) ||
                       (cl_st == CL_PRE)  || (cl_st == CL_HS);
    assign dat_early = (dl_st == DL_STOP) || (dl_st == DL_PREP) || (dl_st == DL_ZERO);
    assign end_req   = pend | burst_end;

    // Early end-of-burst is remembered until the data lane reaches HS active.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   pend <= 1'b0;
        else if (dat_hold || dl_st == DL_HS)          pend <= 1'b0;
        else if (burst_end && clk_busy && dat_early)  pend <= 1'b1;
    end

    dsi_clk_lane_fsm #(.W(CNT_W)) u_clk_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dat_trail(dl_st == DL_TRAIL),
        .abort    (dat_hold),
        .off      (pwr_down[1]),
        .t_prep   (clk_tim[F3-1:F2]),
        .t_zero   (clk_tim[F2-1:F1]),
        .t_pre    (clk_pre),
        .t_post   (clk_tim[F1-1:F0]),
        .t_trail  (clk_tim[F0-1:0]),
        .state    (cl_st),
        .hs_en    (c_hs),
        .lp_en    (c_lp),
        .hs_active(c_act)
    );

    dsi_dat_lane_fsm #(.W(CNT_W)) u_dat_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (cl_st == CL_HS),
        .end_req  (end_req),
        .hold     (dat_hold),
        .t_prep   (dat_tim[F3-1:F2]),
        .t_zero   (dat_tim[F2-1:F1]),
        .t_trail  (dat_tim[F1-1:F0]),
        .t_exit   (dat_tim[F0-1:0]),
        .state    (dl_st),
        .hs_en    (d_hs),
        .lp_en    (d_lp),
        .hs_active(d_act)
    );

    // Enable order: [3] clock hs, [2] clock lp, [1] data hs, [0] data lp.
    logic [N_EN-1:0] fsm_en, alive, en_out;
    assign fsm_en = {c_hs, c_lp, d_hs, d_lp};
    assign alive  = {{2{~pwr_down[1]}}, {2{~(pwr_down[1] | pwr_down[0])}}};

    for (genvar g = 0; g < N_EN; g++) begin : g_en
        assign en_out[g] = alive[g] & (ovr_sel[g] ? ovr_val[g] : fsm_en[g]);
    end

    assign {clk_hs_en, clk_lp_en, dat_hs_en, dat_lp_en} = en_out;

    assign clk_status = {bias_ready, cl_st == CL_STOP, 1'b0, c_act};
    assign dat_status = {1'b0,       dl_st == DL_STOP, 1'b0, d_act};
endmodule

// File: rtl/dsi_lane_seq_chk.sv
module dsi_lane_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_req,
    input logic       force_stop,
    input logic [1:0] pwr_down,
    input logic [3:0] clk_status,
    input logic [3:0] dat_status
);
    // R7: data HS active lies inside clock HS active
    p_dat_in_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dat_status[0] |-> clk_status[0]);

    // R4: the data lane leaves stop only while the clock lane is active
    p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_status[2]) |-> clk_status[0]);

    // R10: force-stop puts the data lane in stop on the next cycle
    p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop |=> dat_status[2]);

    // R11: whole-block power-down stops both lanes
    p_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down[1] |=> (clk_status[2] && dat_status[2]));

    // R2: without a request an idle block stays idle
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_status[2] && dat_status[2] && !hs_req) |=> (clk_status[2] && dat_status[2]));
endmodule

bind dsi_lane_seq dsi_lane_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_req    (hs_req),
    .force_stop(force_stop),
    .pwr_down  (pwr_down),
    .clk_status(clk_status),
    .dat_status(dat_status)
);

// File: tb/dsi_lane_seq_bench.sv
module dsi_lane_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hs_req = 0, burst_end = 0, force_stop = 0, bias_ready = 0;
    logic [1:0] pwr_down = 2'b00;
    logic [4*W-1:0] clk_tim = '0, dat_tim = '0;
    logic [W-1:0] clk_pre = '0;
    logic [3:0] ovr_sel = '0, ovr_val = '0;
    logic clk_hs_en, clk_lp_en, dat_hs_en, dat_lp_en;
    logic [3:0] clk_status, dat_status;

    int n_run = 0, n_fail = 0;

    dsi_lane_seq #(.CNT_W(W)) u_dsi_lane_seq (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .burst_end(burst_end),
        .force_stop(force_stop), .pwr_down(pwr_down), .bias_ready(bias_ready),
        .clk_tim(clk_tim), .dat_tim(dat_tim), .clk_pre(clk_pre),
        .ovr_sel(ovr_sel), .ovr_val(ovr_val),
        .clk_hs_en(clk_hs_en), .clk_lp_en(clk_lp_en),
        .dat_hs_en(dat_hs_en), .dat_lp_en(dat_lp_en),
        .clk_status(clk_status), .dat_status(dat_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dur(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // mode 0: end pulse at a random point; mode 1: idle end pulse first, then a late end
    task automatic run_burst(input int mode);
        int cp, cz, co, ct, dp, dz, dt, dx, rp, hh, b, tt;
        int e_cact, e_dhen, e_dact, e_dactf, e_dhenf, e_dstop, e_cactf, e_cstop;
        logic p_cact, p_dhen, p_dact, p_dstop, p_chen;
        cp = $urandom_range(0, 5); cz = $urandom_range(0, 5);
        co = $urandom_range(0, 5); ct = $urandom_range(0, 5);
        dp = $urandom_range(0, 5); dz = $urandom_range(0, 5);
        dt = $urandom_range(0, 5); dx = $urandom_range(0, 5);
        rp = $urandom_range(0, 4);
        clk_tim = {W'(cp), W'(cz), W'(co), W'(ct)};
        dat_tim = {W'(dp), W'(dz), W'(dt), W'(dx)};
        clk_pre = W'(rp);
        hh = dur(cp) + dur(cz) + dur(rp) + 1 + dur(dp) + dur(dz);
        b  = (mode == 1) ? hh + 4 : $urandom_range(0, hh + 3);
        if (mode == 1) begin
            @(negedge clk) burst_end = 1;
            @(negedge clk) burst_end = 0;
            @(negedge clk);
            check("R5 idle end ignored", int'(clk_hs_en), 0);
        end
        e_cact = -1; e_dhen = -1; e_dact = -1; e_dactf = -1;
        e_dhenf = -1; e_dstop = -1; e_cactf = -1; e_cstop = -1;
        p_cact = 0; p_dhen = 0; p_dact = 0; p_dstop = 1; p_chen = 0;
        @(negedge clk) hs_req = 1;
        @(negedge clk) hs_req = 0;
        for (int i = 0; i < 400; i++) begin
            if (i > 0) @(negedge clk);
            burst_end = (i == b);
            hs_req    = (i == 1);
            if (i == 0) check("R2 clock hs_en after request", int'(clk_hs_en), 1);
            if (clk_status[0] && !p_cact && e_cact < 0) e_cact = i;
            if (!clk_status[0] && p_cact && e_cactf < 0) e_cactf = i;
            if (!clk_hs_en && p_chen && e_cstop < 0) e_cstop = i;
            if (dat_hs_en && !p_dhen && e_dhen < 0) e_dhen = i;
            if (!dat_hs_en && p_dhen && e_dhenf < 0) e_dhenf = i;
            if (dat_status[0] && !p_dact && e_dact < 0) e_dact = i;
            if (!dat_status[0] && p_dact && e_dactf < 0) e_dactf = i;
            if (dat_status[2] && !p_dstop && e_dstop < 0) e_dstop = i;
            p_cact = clk_status[0]; p_chen = clk_hs_en; p_dhen = dat_hs_en;
            p_dact = dat_status[0]; p_dstop = dat_status[2];
            if (e_cstop >= 0 && e_dstop >= 0 && i > b) break;
        end
        burst_end = 0; hs_req = 0;
        tt = max2(hh, b) + 1;
        check("R2 R3 clock prepare+zero", e_cact, dur(cp) + dur(cz));
        check("R4 data launch", e_dhen, dur(cp) + dur(cz) + dur(rp) + 1);
        check("R4 R3 data hs_active start", e_dact, hh);
        check("R5 data hs_active end", e_dactf, tt);
        check("R6 data trail", e_dhenf, tt + dur(dt));
        check("R6 data exit", e_dstop, tt + dur(dt) + dur(dx));
        check("R7 clock post", e_cactf, tt + 1 + dur(co));
        check("R7 clock trail", e_cstop, tt + 1 + dur(co) + dur(ct));
        repeat (3) @(negedge clk);
        check("R12 request during burst ignored", int'(clk_hs_en), 0);
        check("R1 idle lp enables", int'({clk_lp_en, dat_lp_en}), 3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset clk_hs_en", int'(clk_hs_en), 0);
        check("R1 reset dat_hs_en", int'(dat_hs_en), 0);
        check("R1 reset lp enables", int'({clk_lp_en, dat_lp_en}), 3);
        // R8 status encoding
        check("R8 clock status bias low", int'(clk_status), 4'b0100);
        check("R8 data status", int'(dat_status), 4'b0100);
        bias_ready = 1;
        @(negedge clk);
        check("R8 clock status bias high", int'(clk_status), 4'b1100);

        // R9 overrides
        ovr_sel = 4'b0101; ovr_val = 4'b0000;
        @(negedge clk);
        check("R9 lp override", int'({clk_hs_en, clk_lp_en, dat_hs_en, dat_lp_en}), 0);
        ovr_sel = 4'b1010; ovr_val = 4'b1010;
        @(negedge clk);
        check("R9 hs override", int'({clk_hs_en, clk_lp_en, dat_hs_en, dat_lp_en}), 4'b1111);
        check("R9 status unaffected", int'(clk_status[2] & dat_status[2]), 1);
        ovr_sel = 4'b0000; ovr_val = 4'b0000;

        // R3 R4 R5 R6 R7 random bursts, with zero counts included
        run_burst(1);
        for (int k = 0; k < 24; k++) run_burst(0);
        run_burst(1);

        // R10 force-stop during data HS
        clk_tim = {8'd2, 8'd2, 8'd3, 8'd2};
        dat_tim = {8'd1, 8'd1, 8'd2, 8'd2};
        clk_pre = 8'd1;
        @(negedge clk) hs_req = 1;
        @(negedge clk) hs_req = 0;
        for (int i = 0; i < 60; i++) begin
            if (dat_status[0]) break;
            @(negedge clk);
        end
        check("R10 reached data HS", int'(dat_status[0]), 1);
        force_stop = 1;
        @(negedge clk);
        check("R10 data hs_en dropped", int'(dat_hs_en), 0);
        check("R10 data in stop", int'(dat_status[2]), 1);
        check("R10 clock still in post", int'(clk_hs_en), 1);
        repeat (20) @(negedge clk);
        hs_req = 1;
        @(negedge clk) hs_req = 0;
        @(negedge clk);
        check("R10 request ignored while forced", int'(clk_hs_en | dat_hs_en), 0);
        force_stop = 0;

        // R11 power-down
        pwr_down = 2'b10; ovr_sel = 4'hF; ovr_val = 4'hF;
        @(negedge clk);
        check("R11 whole block enables", int'({clk_hs_en, clk_lp_en, dat_hs_en, dat_lp_en}), 0);
        ovr_sel = 4'h0; ovr_val = 4'h0; pwr_down = 2'b01;
        @(negedge clk);
        check("R11 data lane only", int'({clk_hs_en, clk_lp_en, dat_hs_en, dat_lp_en}), 4'b0100);
        pwr_down = 2'b00;
        @(negedge clk) hs_req = 1;
        @(negedge clk) hs_req = 0;
        repeat (8) @(negedge clk);
        check("R11 burst running", int'(clk_status[2]), 0);
        pwr_down = 2'b10;
        @(negedge clk);
        check("R11 both lanes stop", int'({clk_status[2], dat_status[2]}), 3);
        pwr_down = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 idle after power-down", int'({clk_hs_en, dat_hs_en}), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule